// File: doc/BRIEF.md
# SDRAM Per-Bank Open-Row Command Scheduler

This block turns single-beat read and write requests into an abstract stream of SDRAM commands. Each request names a bank, a row, a column and a direction. The block holds, for every bank separately, whether that bank is open and which row it has open. A request that lands on the row already open in its own bank goes out as a bare READ or WRITE. A request to a closed bank is preceded by ACTIVATE. A request to a bank open on another row is preceded by a PRECHARGE of that bank alone and then an ACTIVATE.

The per-bank state lets several access streams that fall into different banks all keep their rows open at once, so alternating between banks costs no reopening. A free-running refresh timer marks a refresh as due at a fixed interval. Once the access in progress has finished, the block closes every bank, issues a refresh and waits out the refresh time. Requests are taken through a valid/ready handshake and served one at a time in arrival order.

Top module: `sdram_bank_sched`

## Requirements
- R1: Command codes on `cmd` are NOP=0, ACTIVATE=1, READ=2, WRITE=3, PRECHARGE=4, PRECHARGE-ALL=5, AUTO-REFRESH=6. During and after reset `cmd` is NOP, `req_ready` is 1 and every bank is closed, so the first request to any bank starts with ACTIVATE.
- R2: When the requested bank is open on the requested row, the cycle after acceptance carries READ (`req_write`=0) or WRITE (`req_write`=1) with the bank on `cmd_bank` and the column on `cmd_addr`, and no ACTIVATE or PRECHARGE.
- R3: When the requested bank is closed, the cycle after acceptance carries ACTIVATE with the row on `cmd_addr`, and the READ or WRITE follows exactly T_RCD cycles after the ACTIVATE with NOP in between.
- R4: When the requested bank is open on another row, the cycle after acceptance carries PRECHARGE to that bank only, ACTIVATE follows T_RP cycles later, and the access follows T_RCD cycles after that.
- R5: The open row of one bank has no effect on another bank: a row open in bank A does not make the same row a hit in bank B, and rows opened in several banks all stay open, so alternating hits across banks issue no PRECHARGE or ACTIVATE.
- R6: A refresh becomes due every REF_PERIOD cycles. It is carried out as PRECHARGE-ALL, then AUTO-REFRESH T_RP cycles later, then `req_ready` returns T_RFC cycles after AUTO-REFRESH, with every bank closed.
- R7: A refresh that becomes due while an access sequence is running waits until that sequence has issued its READ or WRITE; no sequence is cut short.
- R8: `req_ready` is 1 only when no sequence is running and no refresh is due; every accepted request yields a non-NOP command in the next cycle, and requests are served strictly in the order accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A request is presented |
| req_ready | output | 1 | The block takes the request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | BANK_W | Bank of the request |
| req_row | input | ROW_W | Row of the request |
| req_col | input | COL_W | Column of the request |
| cmd | output | 3 | Command code (see R1) |
| cmd_bank | output | BANK_W | Bank the command targets |
| cmd_addr | output | ADDR_W | Row for ACTIVATE, column for READ/WRITE, else 0 |

## Verification
The hardest situation to reach is a refresh falling due in the middle of a precharge-activate-access sequence, since the handshake hides the refresh timer and an idle block refreshes at once. The stimulus sends back-to-back row misses across all banks for several refresh periods, so the handshake is low in most cycles and the timer is bound to expire inside a running sequence; each sequence is compared cycle by cycle against the expected command trace. Rows are swept over every bank and row of a small configuration, and refreshes are tracked from the command port so that the bench's bank model closes all banks when they occur.

// File: rtl/sdram_bank_pkg.sv
package sdram_bank_pkg;

    typedef enum logic [2:0] {
        CMD_NOP   = 3'd0,
        CMD_ACT   = 3'd1,
        CMD_READ  = 3'd2,
        CMD_WRITE = 3'd3,
        CMD_PRE   = 3'd4,
        CMD_PREA  = 3'd5,
        CMD_REF   = 3'd6
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_PRE_WAIT  = 3'd1,
        ST_ACT_WAIT  = 3'd2,
        ST_REFP_WAIT = 3'd3,
        ST_REF_WAIT  = 3'd4
    } state_e;

endpackage

// File: rtl/sdram_bank_table.sv
module sdram_bank_table #(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 13,
    parameter int BANK_W    = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              open_en,
    input  logic                              close_en,
    input  logic                              close_all,
    input  logic [BANK_W-1:0]                 sel_bank,
    input  logic [ROW_W-1:0]                  new_row,
    output logic [NUM_BANKS-1:0]              bank_open,
    output logic [NUM_BANKS-1:0][ROW_W-1:0]   bank_row
);

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        logic             open_d, open_q;
        logic [ROW_W-1:0] row_d, row_q;
        logic             hit_sel;

        assign hit_sel = (sel_bank == BANK_W'(g));

        always_comb begin
            open_d = open_q;
            row_d  = row_q;
            if (close_all || (close_en && hit_sel)) begin
                open_d = 1'b0;
            end else if (open_en && hit_sel) begin
                open_d = 1'b1;
                row_d  = new_row;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                open_q <= 1'b0;
                row_q  <= '0;
            end else begin
                open_q <= open_d;
                row_q  <= row_d;
            end
        end

        assign bank_open[g] = open_q;
        assign bank_row[g]  = row_q;
    end

endmodule

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
    parameter int REF_PERIOD = 780
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic pending
);

    localparam int CNT_W = (REF_PERIOD > 2) ? $clog2(REF_PERIOD) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(REF_PERIOD - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             pend_d, pend_q;

    always_comb begin
        cnt_d  = cnt_q + CNT_W'(1);
        pend_d = pend_q;
        if (clear) begin
            pend_d = 1'b0;
        end
        if (cnt_q == LAST) begin
            cnt_d  = '0;
            pend_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            pend_q <= pend_d;
        end
    end

    assign pending = pend_q;

endmodule

// File: rtl/sdram_bank_sched.sv
module sdram_bank_sched
    import sdram_bank_pkg::*;
#(
    parameter int NUM_BANKS  = 4,
    parameter int ROW_W      = 13,
    parameter int COL_W      = 10,
    parameter int T_RCD      = 2,
    parameter int T_RP       = 2,
    parameter int T_RFC      = 7,
    parameter int REF_PERIOD = 780,
    localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int ADDR_W    = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    output logic [2:0]        cmd,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ADDR_W-1:0] cmd_addr
);

    localparam int WAIT_MAX = (T_RFC > T_RP) ? ((T_RFC > T_RCD) ? T_RFC : T_RCD)
                                             : ((T_RP > T_RCD) ? T_RP : T_RCD);
    localparam int CNT_W    = $clog2(WAIT_MAX + 1);

    typedef struct packed {
        state_e              st;
        logic [CNT_W-1:0]    cnt;
        logic                wr;
        logic [BANK_W-1:0]   bank;
        logic [ROW_W-1:0]    row;
        logic [COL_W-1:0]    col;
        cmd_e                cmd;
        logic [BANK_W-1:0]   cbank;
        logic [ADDR_W-1:0]   caddr;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                            ref_pend, ref_clear;
    logic                            tbl_open, tbl_close, tbl_close_all;
    logic [BANK_W-1:0]               tbl_bank;
    logic [ROW_W-1:0]                tbl_row;
    logic [NUM_BANKS-1:0]            bank_open;
    logic [NUM_BANKS-1:0][ROW_W-1:0] bank_row;
    logic                            req_bank_open, req_hit;

    sdram_bank_table #(
        .NUM_BANKS (NUM_BANKS),
        .ROW_W     (ROW_W),
        .BANK_W    (BANK_W)
    ) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .open_en   (tbl_open),
        .close_en  (tbl_close),
        .close_all (tbl_close_all),
        .sel_bank  (tbl_bank),
        .new_row   (tbl_row),
        .bank_open (bank_open),
        .bank_row  (bank_row)
    );

    sdram_refresh_timer #(
        .REF_PERIOD (REF_PERIOD)
    ) u_refresh (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (ref_clear),
        .pending (ref_pend)
    );

    assign req_bank_open = bank_open[req_bank];
    assign req_hit       = req_bank_open && (bank_row[req_bank] == req_row);
    assign req_ready     = (ctl_q.st == ST_IDLE) && !ref_pend;

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.cmd     = CMD_NOP;
        ctl_d.cbank   = '0;
        ctl_d.caddr   = '0;
        tbl_open      = 1'b0;
        tbl_close     = 1'b0;
        tbl_close_all = 1'b0;
        tbl_bank      = ctl_q.bank;
        tbl_row       = ctl_q.row;
        ref_clear     = 1'b0;

        unique case (ctl_q.st)
            ST_IDLE: begin
                if (ref_pend) begin
                    ctl_d.cmd     = CMD_PREA;
                    tbl_close_all = 1'b1;
                    ctl_d.st      = ST_REFP_WAIT;
                    ctl_d.cnt     = CNT_W'(T_RP - 1);
                end else if (req_valid) begin
                    ctl_d.wr    = req_write;
                    ctl_d.bank  = req_bank;
                    ctl_d.row   = req_row;
                    ctl_d.col   = req_col;
                    ctl_d.cbank = req_bank;
                    tbl_bank    = req_bank;
                    tbl_row     = req_row;
                    if (req_hit) begin
                        ctl_d.cmd   = req_write ? CMD_WRITE : CMD_READ;
                        ctl_d.caddr = ADDR_W'(req_col);
                    end else if (req_bank_open) begin
                        ctl_d.cmd = CMD_PRE;
                        tbl_close = 1'b1;
                        ctl_d.st  = ST_PRE_WAIT;
                        ctl_d.cnt = CNT_W'(T_RP - 1);
                    end else begin
                        ctl_d.cmd   = CMD_ACT;
                        ctl_d.caddr = ADDR_W'(req_row);
                        tbl_open    = 1'b1;
                        ctl_d.st    = ST_ACT_WAIT;
                        ctl_d.cnt   = CNT_W'(T_RCD - 1);
                    end
                end
            end
            ST_PRE_WAIT: begin
                if (ctl_q.cnt == '0) begin
                    ctl_d.cmd   = CMD_ACT;
                    ctl_d.cbank = ctl_q.bank;
                    ctl_d.caddr = ADDR_W'(ctl_q.row);
                    tbl_open    = 1'b1;
                    ctl_d.st    = ST_ACT_WAIT;
                    ctl_d.cnt   = CNT_W'(T_RCD - 1);
                end else begin
                    ctl_d.cnt = ctl_q.cnt - CNT_W'(1);
                end
            end
            ST_ACT_WAIT: begin
                if (ctl_q.cnt == '0) begin
                    ctl_d.cmd   = ctl_q.wr ? CMD_WRITE : CMD_READ;
                    ctl_d.cbank = ctl_q.bank;
                    ctl_d.caddr = ADDR_W'(ctl_q.col);
                    ctl_d.st    = ST_IDLE;
                end else begin
                    ctl_d.cnt = ctl_q.cnt - CNT_W'(1);
                end
            end
            ST_REFP_WAIT: begin
                if (ctl_q.cnt == '0) begin
                    ctl_d.cmd = CMD_REF;
                    ref_clear = 1'b1;
                    ctl_d.st  = ST_REF_WAIT;
                    ctl_d.cnt = CNT_W'(T_RFC - 1);
                end else begin
                    ctl_d.cnt = ctl_q.cnt - CNT_W'(1);
                end
            end
            ST_REF_WAIT: begin
                if (ctl_q.cnt == '0) begin
                    ctl_d.st = ST_IDLE;
                end else begin
                    ctl_d.cnt = ctl_q.cnt - CNT_W'(1);
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign cmd      = ctl_q.cmd;
    assign cmd_bank = ctl_q.cbank;
    assign cmd_addr = ctl_q.caddr;

endmodule

// File: rtl/sdram_bank_sched_chk.sv
module sdram_bank_sched_chk
    import sdram_bank_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = 2,
    parameter int T_RCD     = 2,
    parameter int T_RP      = 2,
    parameter int T_RFC     = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [2:0]        cmd,
    input logic [BANK_W-1:0] cmd_bank
);

    logic [NUM_BANKS-1:0] ck_open;
    logic [15:0]          since_act, since_pre, since_ref;

    function automatic logic [15:0] sat_inc(input logic [15:0] v);
        return (v == 16'hFFFF) ? v : v + 16'd1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ck_open   <= '0;
            since_act <= 16'hFFFF;
            since_pre <= 16'hFFFF;
            since_ref <= 16'hFFFF;
        end else begin
            since_act <= (cmd == CMD_ACT) ? 16'd1 : sat_inc(since_act);
            since_pre <= (cmd == CMD_PRE || cmd == CMD_PREA) ? 16'd1 : sat_inc(since_pre);
            since_ref <= (cmd == CMD_REF) ? 16'd1 : sat_inc(since_ref);
            if (cmd == CMD_ACT)  ck_open[cmd_bank] <= 1'b1;
            if (cmd == CMD_PRE)  ck_open[cmd_bank] <= 1'b0;
            if (cmd == CMD_PREA) ck_open <= '0;
        end
    end

    p_reset_nop_r1: assert property (@(posedge clk) !rst_n |=> cmd == CMD_NOP);

    p_access_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_READ || cmd == CMD_WRITE) |-> ck_open[cmd_bank]);

    p_rcd_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_READ || cmd == CMD_WRITE) |-> since_act >= 16'(T_RCD));

    p_rp_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_ACT || cmd == CMD_REF) |-> since_pre >= 16'(T_RP));

    p_act_closed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_ACT) |-> !ck_open[cmd_bank]);

    p_ref_closed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_REF) |-> ck_open == '0);

    p_rfc_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != CMD_NOP) |-> since_ref >= 16'(T_RFC));

    p_accept_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> cmd != CMD_NOP);

endmodule

bind sdram_bank_sched sdram_bank_sched_chk #(
    .NUM_BANKS (NUM_BANKS),
    .BANK_W    (BANK_W),
    .T_RCD     (T_RCD),
    .T_RP      (T_RP),
    .T_RFC     (T_RFC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .cmd       (cmd),
    .cmd_bank  (cmd_bank)
);

// File: tb/sdram_bank_sched_test.sv
`timescale 1ns/1ps
module sdram_bank_sched_test;

    localparam int NB   = 4;
    localparam int RW   = 3;
    localparam int CW   = 4;
    localparam int BW   = 2;
    localparam int AW   = 4;
    localparam int TRCD = 2;
    localparam int TRP  = 2;
    localparam int TRFC = 7;
    localparam int REFP = 150;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [BW-1:0] req_bank = '0;
    logic [RW-1:0] req_row = '0;
    logic [CW-1:0] req_col = '0;
    logic [2:0]    cmd;
    logic [BW-1:0] cmd_bank;
    logic [AW-1:0] cmd_addr;

    always #10 clk = ~clk;

    sdram_bank_sched #(
        .NUM_BANKS (NB), .ROW_W (RW), .COL_W (CW),
        .T_RCD (TRCD), .T_RP (TRP), .T_RFC (TRFC), .REF_PERIOD (REFP)
    ) uut (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
        .req_bank (req_bank), .req_row (req_row), .req_col (req_col),
        .cmd (cmd), .cmd_bank (cmd_bank), .cmd_addr (cmd_addr)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit m_open [NB];
    int m_row  [NB];
    int ref_seen = 0;
    int t_prea = -1;
    int t_prea_prev = -1;
    int t_ref = 0;
    bit exp_rdy = 1'b0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk = n_chk + 1;
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual=%0d cycles expected=finish", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk = n_chk + 1;
        if (act != exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Called once per negedge while no request sequence is running.
    task automatic observe();
        if (cmd == 3'd5) begin
            chk("R8 ready low when refresh starts", int'(req_ready), 0);
            for (int i = 0; i < NB; i++) m_open[i] = 1'b0;
            t_prea_prev = t_prea;
            t_prea = cyc;
        end else if (cmd == 3'd6) begin
            chk("R6 PREA to REF gap", cyc - t_prea, TRP);
            t_ref = cyc;
            ref_seen = ref_seen + 1;
            exp_rdy = 1'b1;
        end else begin
            chk("R8 no command without a request", int'(cmd), 0);
        end
        if (exp_rdy && req_ready) begin
            chk("R6 REF to ready gap", cyc - t_ref, TRFC);
            exp_rdy = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            observe();
        end
    endtask

    task automatic wait_ready();
        while (!req_ready) begin
            @(negedge clk);
            observe();
        end
    endtask

    task automatic expect_cmd(input string tag, input int c, input int b,
                              input int a, input bit use_a);
        chk({tag, " cmd"}, int'(cmd), c);
        chk({tag, " bank"}, int'(cmd_bank), b);
        if (use_a) chk({tag, " addr"}, int'(cmd_addr), a);
    endtask

    task automatic expect_gap(input string tag, input int n);
        repeat (n) begin
            @(negedge clk);
            chk({tag, " NOP gap"}, int'(cmd), 0);
            chk({tag, " R8 ready low in sequence"}, int'(req_ready), 0);
        end
    endtask

    // Issues one request and compares the full command trace (R8 order).
    task automatic issue(input int b, input int r, input int c, input bit w,
                         input string tag);
        int acc;
        int kind;
        wait_ready();
        if (m_open[b] && m_row[b] == r) kind = 0;
        else if (m_open[b])             kind = 2;
        else                            kind = 1;
        acc = w ? 3 : 2;
        req_valid = 1'b1;
        req_write = w;
        req_bank  = BW'(b);
        req_row   = RW'(r);
        req_col   = CW'(c);
        @(negedge clk);
        req_valid = 1'b0;
        if (kind == 0) begin
            expect_cmd({tag, " R2 hit access"}, acc, b, c, 1'b1);
        end else if (kind == 1) begin
            expect_cmd({tag, " R3 activate closed"}, 1, b, r, 1'b1);
            expect_gap({tag, " R3"}, TRCD - 1);
            @(negedge clk);
            expect_cmd({tag, " R3 access after tRCD"}, acc, b, c, 1'b1);
        end else begin
            expect_cmd({tag, " R4 precharge bank"}, 4, b, 0, 1'b0);
            expect_gap({tag, " R4"}, TRP - 1);
            @(negedge clk);
            expect_cmd({tag, " R4 activate after tRP"}, 1, b, r, 1'b1);
            expect_gap({tag, " R4"}, TRCD - 1);
            @(negedge clk);
            expect_cmd({tag, " R4 access after tRCD"}, acc, b, c, 1'b1);
        end
        m_open[b] = 1'b1;
        m_row[b]  = r;
    endtask

    initial begin
        int rs0;
        for (int i = 0; i < NB; i++) begin
            m_open[i] = 1'b0;
            m_row[i]  = 0;
        end

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 cmd NOP in reset", int'(cmd), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 cmd NOP after reset", int'(cmd), 0);
        chk("R1 ready after reset", int'(req_ready), 1);
        chk("R1 cmd_addr zero after reset", int'(cmd_addr), 0);

        // R1/R3: first touch of every bank opens it
        for (int b = 0; b < NB; b++) issue(b, 1, b, 1'b0, "R1 first touch");

        // R2/R4: sweep every row of every bank, read then write-hit
        for (int b = 0; b < NB; b++) begin
            for (int r = 0; r < (1 << RW); r++) begin
                issue(b, r, (r + b) % (1 << CW), 1'b0, "sweep read");
                issue(b, r, (r * 3 + 1) % (1 << CW), 1'b1, "sweep write");
            end
        end

        // R6: let a refresh close everything, then R5 same row in two banks
        idle(REFP + TRP + TRFC + 4);
        issue(0, 5, 2, 1'b0, "R5 bank0 row5");
        issue(1, 5, 3, 1'b0, "R5 bank1 same row is not a hit");
        issue(0, 5, 4, 1'b1, "R5 bank0 still open");

        // R5: open a row in every bank, then alternate hits
        for (int b = 0; b < NB; b++) issue(b, b + 2, b, 1'b0, "R5 open");
        for (int k = 0; k < 3; k++)
            for (int b = 0; b < NB; b++)
                issue(b, b + 2, (k * 4 + b) % (1 << CW), k[0], "R5 interleave");

        // R7: back-to-back misses across several refresh periods
        rs0 = ref_seen;
        for (int i = 0; i < 160; i++)
            issue(i % NB, (i / NB) % (1 << RW), i % (1 << CW), i[1], "R7 miss stream");
        chk("R7 refreshes occurred during miss stream", int'(ref_seen > rs0 + 1), 1);

        // R6: refresh period while idle
        idle(3 * REFP);
        chk("R6 refresh period", t_prea - t_prea_prev, REFP);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule